// File: doc/BRIEF.md
# Free-Running Time-Base Counter

This block is a loadable 16-bit up-counter. It runs freely and gives a common time reference to the capture and compare channels around it. A control register picks what makes it count. The source is one of six prescaler taps, each of which arrives as a one-cycle enable pulse, or an external pin. The pin is synchronized and edge-detected, and its active edge can be chosen.

No source has any effect until the global prescaler-run input is high. Because of this, every counter fed from the same prescaler starts in the same cycle. Software can read the count and load a new value over a small register bus. When the count wraps from full scale to zero, a sticky flag is set. That flag can raise an interrupt at a programmable level. The count can also be driven onto either or both of two shared time-base buses.

Top module: `ftb_timebase`

Register map (`reg_addr`): 0 = count, 1 = control, 2 = status. Address 3 reads as zero.
- Control register: bits [2:0] are the source code, bit 3 is the edge select, bit 4 enables bus A and bit 5 enables bus B.
- Status register: bit 0 is the overflow flag and bits [3:1] are the interrupt level.

## Requirements
- R1: A synchronous reset clears the count, control, status, read data, bus outputs and interrupt outputs to zero.
- R2: While `prescaler_run` is low, neither tap pulses nor pin edges change the count.
- R3: Source codes 0 to 5 select `tap_pulse[code]`. With run high, each pulse on the selected tap raises the count by one in the next cycle. Pulses on other taps are ignored. Code 7 selects no source.
- R4: Source code 6 counts edges on `ext_pin`. Control bit 3 = 0 selects rising edges and 1 selects falling edges. Each active edge adds one, at most three cycles after the pin changes. Edges of the other direction are ignored.
- R5: A write to address 0 loads `reg_wdata` into the count at the next edge. This load wins over a count pulse in the same cycle.
- R6: A read (`reg_sel` and `reg_rd`) returns the addressed register on `reg_rdata` one cycle later.
- R7: A count step from 0xFFFF to 0x0000 sets the status overflow flag (bit 0). The flag stays set.
- R8: Loading 0x0000 while the count is 0xFFFF does not set the overflow flag. This holds even when a count pulse arrives in the same cycle.
- R9: Writing 1 to status bit 0 clears the flag and writing 0 leaves it unchanged. If an overflow happens in the same cycle as a clear, the flag stays set.
- R10: `irq_req` is high one cycle after the flag is set and the level is nonzero. Level 0 keeps `irq_req` low. `irq_level` follows status bits [3:1].
- R11: With control bit 4 (or bit 5) set, `tbus_a` (or `tbus_b`) carries the count with a one-cycle lag, and its enable output is high. With the bit clear, the bus outputs zero and its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prescaler_run | input | 1 | Global enable for all count sources |
| tap_pulse | input | 6 | One-cycle enable pulses from the prescaler taps |
| ext_pin | input | 1 | Asynchronous external count input |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_req | output | 1 | Overflow interrupt request |
| irq_level | output | 3 | Interrupt level of the request |
| tbus_a | output | 16 | Time-base bus A data |
| tbus_a_en | output | 1 | Bus A drive enable |
| tbus_b | output | 16 | Time-base bus B data |
| tbus_b_en | output | 1 | Bus B drive enable |

## Verification
The hardest cases are those where a count pulse arrives in the same cycle as a software access. Examples are a load of zero at full scale with a pending tap pulse, and a flag clear in the same cycle as a wrap. The bench reaches them with a write task that raises a chosen tap pulse in the same cycle as the register strobe. It first preloads 0xFFFF so that the pulse would otherwise cause a wrap. Pin edges are checked in both polarities, and the polarity is changed while the pin is steady so that no false edge is produced.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  localparam int CNT_W   = 16;
  localparam int N_TAPS  = 6;
  localparam int SRC_W   = $clog2(N_TAPS + 2);
  localparam int LVL_W   = 3;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int CTL_POL_BIT  = SRC_W;
  localparam int CTL_DRVA_BIT = SRC_W + 1;
  localparam int CTL_DRVB_BIT = SRC_W + 2;

  typedef struct packed {
    logic             drv_b;
    logic             drv_a;
    logic             fall_edge;
    logic [SRC_W-1:0] src;
  } ctrl_t;
endpackage

// File: rtl/ftb_edge_sync.sv
module ftb_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic pulse
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign pulse = fall_sel ? (prev & ~s2) : (s2 & ~prev);

  // R4: one detected edge gives a single-cycle count enable
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> (!pulse || (fall_sel != $past(fall_sel))));
endmodule

// File: rtl/ftb_src_sel.sv
module ftb_src_sel #(
  parameter int N_TAPS = 6,
  parameter int SRC_W  = $clog2(N_TAPS + 2)
) (
  input  logic              run,
  input  logic [SRC_W-1:0]  src,
  input  logic [N_TAPS-1:0] taps,
  input  logic              ext_pulse,
  output logic              tick
);
  localparam logic [SRC_W-1:0] EXT_CODE = SRC_W'(N_TAPS);

  logic [N_TAPS-1:0] hit;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign hit[i] = taps[i] & (src == SRC_W'(i));
  end

  assign tick = run & ((|hit) | (ext_pulse & (src == EXT_CODE)));
endmodule

// File: rtl/ftb_counter.sv
module ftb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = tick & ~load & (count == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + W'(1);
  end

  // R5: software load wins over a count enable
  a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
  // R3: one step per enable
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> count == $past(count) + W'(1));
  // R2: no enable, no load: value holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> count == $past(count));
endmodule

// File: rtl/ftb_timebase.sv
module ftb_timebase
  import ftb_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int TAPS   = N_TAPS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prescaler_run,
  input  logic [TAPS-1:0] tap_pulse,
  input  logic            ext_pin,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  output logic            irq_req,
  output logic [LVL_W-1:0] irq_level,
  output logic [W-1:0]    tbus_a,
  output logic            tbus_a_en,
  output logic [W-1:0]    tbus_b,
  output logic            tbus_b_en
);
  localparam int SW = $clog2(TAPS + 2);

  logic [SW-1:0]    src_q;
  logic             fall_q, drva_q, drvb_q;
  logic             ovf_q;
  logic [LVL_W-1:0] lvl_q;
  logic [W-1:0]     count;
  logic             wrap, tick, ext_pulse;
  logic             cnt_wr, ctl_wr, stat_wr, rd_en;

  assign cnt_wr  = reg_sel & reg_wr & (reg_addr == ADDR_COUNT);
  assign ctl_wr  = reg_sel & reg_wr & (reg_addr == ADDR_CTRL);
  assign stat_wr = reg_sel & reg_wr & (reg_addr == ADDR_STATUS);
  assign rd_en   = reg_sel & reg_rd;

  ftb_edge_sync u_edge (
    .clk(clk), .rst(rst), .pin(ext_pin), .fall_sel(fall_q), .pulse(ext_pulse)
  );

  ftb_src_sel #(.N_TAPS(TAPS), .SRC_W(SW)) u_sel (
    .run(prescaler_run), .src(src_q), .taps(tap_pulse),
    .ext_pulse(ext_pulse), .tick(tick)
  );

  ftb_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_wr),
    .load_val(reg_wdata), .count(count), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      fall_q <= 1'b0;
      drva_q <= 1'b0;
      drvb_q <= 1'b0;
    end else if (ctl_wr) begin
      src_q  <= reg_wdata[SW-1:0];
      fall_q <= reg_wdata[SW];
      drva_q <= reg_wdata[SW+1];
      drvb_q <= reg_wdata[SW+2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (wrap)                        ovf_q <= 1'b1;
      else if (stat_wr && reg_wdata[0]) ovf_q <= 1'b0;
      if (stat_wr) lvl_q <= reg_wdata[LVL_W:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_req   <= 1'b0;
      irq_level <= '0;
      tbus_a    <= '0;
      tbus_b    <= '0;
      tbus_a_en <= 1'b0;
      tbus_b_en <= 1'b0;
    end else begin
      if (rd_en) begin
        case (reg_addr)
          ADDR_COUNT:  reg_rdata <= count;
          ADDR_CTRL:   reg_rdata <= W'({drvb_q, drva_q, fall_q, src_q});
          ADDR_STATUS: reg_rdata <= W'({lvl_q, ovf_q});
          default:     reg_rdata <= '0;
        endcase
      end
      irq_req   <= ovf_q & (lvl_q != '0);
      irq_level <= lvl_q;
      tbus_a    <= drva_q ? count : '0;
      tbus_b    <= drvb_q ? count : '0;
      tbus_a_en <= drva_q;
      tbus_b_en <= drvb_q;
    end
  end

  // R7: a wrap leaves the flag set
  a_r7_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_q);
  // R8: loading zero at full scale does not raise the flag
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && count == {W{1'b1}} && !ovf_q) |=> !ovf_q);
  // R2: held while run is low
  a_r2_run_gate: assert property (@(posedge clk) disable iff (rst)
    (!prescaler_run && !cnt_wr) |=> count == $past(count));
  // R10: level 0 masks the request
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0) |=> !irq_req);
  // R11: a disabled bus outputs zero
  a_r11_bus_off: assert property (@(posedge clk) disable iff (rst)
    !drva_q |=> (tbus_a == '0 && !tbus_a_en));
endmodule

// File: tb/ftb_timebase_tb.sv
module ftb_timebase_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        run;
  logic [5:0]  taps;
  logic        pin;
  logic        sel, wr, rd;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  logic [2:0]  lvl;
  logic [15:0] ba, bb;
  logic        ba_en, bb_en;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ftb_timebase u_dut (
    .clk(clk), .rst(rst), .prescaler_run(run), .tap_pulse(taps), .ext_pin(pin),
    .reg_sel(sel), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_req(irq), .irq_level(lvl),
    .tbus_a(ba), .tbus_a_en(ba_en), .tbus_b(bb), .tbus_b_en(bb_en)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write, optionally with a tap pulse in the same cycle (tap < 0: none)
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d, input int tap = -1);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    if (tap >= 0) taps[tap] = 1'b1;
    @(negedge clk);
    sel = 0; wr = 0; taps = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    sel = 1; rd = 1; addr = a;
    @(negedge clk);
    sel = 0; rd = 0;
    d = rdata;
  endtask

  task automatic pulse_tap(input int i);
    @(negedge clk);
    taps[i] = 1'b1;
    @(negedge clk);
    taps = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 rdata", rdata, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 bus a", ba, 16'h0);
    check("R1 bus b en", {15'b0, bb_en}, 16'h0);
    rd_reg(2'd0, v); check("R1 count", v, 16'h0);
    rd_reg(2'd2, v); check("R1 status", v, 16'h0);
  endtask

  task automatic t_run_gate;
    logic [15:0] v;
    run = 0;
    wr_reg(2'd1, 16'h0000);
    pulse_tap(0); pulse_tap(0);
    rd_reg(2'd0, v); check("R2 taps gated", v, 16'h0);
    wr_reg(2'd1, 16'h0006);
    pin = 1; cyc(5); pin = 0; cyc(5);
    rd_reg(2'd0, v); check("R2 pin gated", v, 16'h0);
    run = 1;
    wr_reg(2'd1, 16'h0000);
    pulse_tap(0);
    rd_reg(2'd0, v); check("R2 counts after run", v, 16'h1);
  endtask

  task automatic t_taps;
    logic [15:0] v;
    wr_reg(2'd0, 16'h0100);
    wr_reg(2'd1, 16'h0003);
    pulse_tap(2); pulse_tap(4);
    rd_reg(2'd0, v); check("R3 other taps ignored", v, 16'h0100);
    pulse_tap(3); pulse_tap(3); pulse_tap(3);
    rd_reg(2'd0, v); check("R3 tap3 counts", v, 16'h0103);
    wr_reg(2'd1, 16'h0005);
    pulse_tap(5);
    rd_reg(2'd0, v); check("R3 tap5 counts", v, 16'h0104);
    wr_reg(2'd1, 16'h0007);
    for (int i = 0; i < 6; i++) pulse_tap(i);
    rd_reg(2'd0, v); check("R3 code 7 idle", v, 16'h0104);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    pin = 0;
    wr_reg(2'd1, 16'h0006);
    wr_reg(2'd0, 16'h0000);
    cyc(4);
    pin = 1; cyc(4);
    rd_reg(2'd0, v); check("R4 rising counted", v, 16'h1);
    pin = 0; cyc(4);
    rd_reg(2'd0, v); check("R4 falling ignored", v, 16'h1);
    wr_reg(2'd1, 16'h000E);
    cyc(2);
    pin = 1; cyc(4);
    rd_reg(2'd0, v); check("R4 rising ignored in falling mode", v, 16'h1);
    pin = 0; cyc(4);
    rd_reg(2'd0, v); check("R4 falling counted", v, 16'h2);
  endtask

  task automatic t_load;
    logic [15:0] v;
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd0, 16'h1234, 0);
    rd_reg(2'd0, v); check("R5 load wins over tick", v, 16'h1234);
    rd_reg(2'd1, v); check("R6 control readback", v, 16'h0000);
    wr_reg(2'd1, 16'h0002);
    rd_reg(2'd1, v); check("R6 control readback 2", v, 16'h0002);
    rd_reg(2'd3, v); check("R6 unused address", v, 16'h0);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd2, 16'h0001);
    wr_reg(2'd0, 16'hFFFF);
    wr_reg(2'd0, 16'h0000, 0);
    rd_reg(2'd2, v); check("R8 zero load at full scale", v, 16'h0);
    rd_reg(2'd0, v); check("R8 count zero", v, 16'h0);
    wr_reg(2'd0, 16'hFFFF);
    pulse_tap(0);
    rd_reg(2'd0, v); check("R7 wrapped", v, 16'h0);
    rd_reg(2'd2, v); check("R7 flag set", v, 16'h1);
    pulse_tap(0); cyc(3);
    rd_reg(2'd2, v); check("R7 flag sticky", v, 16'h1);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    wr_reg(2'd2, 16'h0000);
    rd_reg(2'd2, v); check("R9 write 0 keeps flag", v, 16'h1);
    wr_reg(2'd2, 16'h0001);
    rd_reg(2'd2, v); check("R9 write 1 clears", v, 16'h0);
    wr_reg(2'd0, 16'hFFFF);
    wr_reg(2'd2, 16'h0001, 0);
    rd_reg(2'd2, v); check("R9 set beats clear", v, 16'h1);
  endtask

  task automatic t_irq;
    wr_reg(2'd2, 16'h0000);
    cyc(2);
    check("R10 level 0 masks", {15'b0, irq}, 16'h0);
    wr_reg(2'd2, 16'h000A);
    cyc(1);
    check("R10 irq raised", {15'b0, irq}, 16'h1);
    check("R10 level out", {13'b0, lvl}, 16'h5);
    wr_reg(2'd2, 16'h000B);
    cyc(1);
    check("R10 irq drops on clear", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_bus;
    wr_reg(2'd0, 16'hBEEF);
    wr_reg(2'd1, 16'h0017);
    cyc(2);
    check("R11 bus a data", ba, 16'hBEEF);
    check("R11 bus a en", {15'b0, ba_en}, 16'h1);
    check("R11 bus b off", bb, 16'h0);
    wr_reg(2'd1, 16'h0027);
    cyc(2);
    check("R11 bus b data", bb, 16'hBEEF);
    check("R11 bus a off", {15'b0, ba_en}, 16'h0);
    check("R11 bus a zero", ba, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1; run = 0; taps = '0; pin = 0;
    sel = 0; wr = 0; rd = 0; addr = '0; wdata = '0;
    cyc(3);
    rst = 0;
    cyc(1);
    t_reset();
    t_run_gate();
    t_taps();
    t_ext();
    t_load();
    t_overflow();
    t_clear();
    t_irq();
    t_bus();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule